// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Register Bank

This block is the shared register bank that sits beside a set of DMA channel engines. Software reaches it through a simple 32-bit word bus with one request per cycle. Through the bank it starts and stops channels, arms them for looping transfers, and masks and acknowledges their completion events. The engines report completion with one event pulse per channel. The bank keeps those events as sticky status bits and merges the enabled ones into a single interrupt line.

Each channel's start is triggered by a write to that channel's address word. This write is the last one in a channel's setup sequence, and the engine begins its transfer on the pulse it receives. A stop is requested by writing ones to the invalidate word, one bit per channel. A channel runs in loop mode only while both of its two enable bits in the loop word are set: the low bit sits at position n and the high bit at position n+16. The address, length and stride storage of the engines is not part of this block. Those offsets read as zero here.

Top module: `dmareg_bank`

## Requirements
- R1: After reset the status, enable and loop words read zero, and irq_o, ch_start_o, ch_stop_o and loop_en_o are all zero.
- R2: An evt_i[n] pulse sets bit n of the status word at byte offset 0x144. The bit reads back as set and stays set with no further event.
- R3: A write to 0x144 clears every status bit whose data bit is 1. Bits written with 0 are unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable word at 0x148 holds one read/write bit per channel in bits [15:0]. Bits [31:16] read zero.
- R6: irq_o is 1 exactly when some status bit and the matching enable bit are both set. It changes in the same cycle as the status and enable words.
- R7: Writing the invalidate word at 0x140 with bit n set drives ch_stop_o[n] high for exactly one cycle, in the cycle after the write. That word reads zero.
- R8: The loop word at 0x150 stores bits [15:0] and [31:16], and they read back as written. loop_en_o[n] is 1 only when both bit n and bit n+16 are set.
- R9: A write to byte offset n*0x10 (n = 0..15) drives ch_start_o[n] high for exactly one cycle, in the cycle after the write, whatever the data. No other channel pulses.
- R10: Reads of any other offset return zero, including 0x04/0x08/0x0C within a channel and the region 0x100 to 0x13C. Writes to those offsets change no register and no output.
- R11: Read data appears on rd_data_o in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte address of the register word |
| req_wdata | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| evt_i | input | 16 | Per-channel completion event pulses |
| irq_o | output | 1 | Combined interrupt |
| ch_start_o | output | 16 | Per-channel start pulse |
| ch_stop_o | output | 16 | Per-channel stop pulse |
| loop_en_o | output | 16 | Per-channel loop-mode enable |

## Verification
The assertions check on every cycle that each event leaves its status bit set, and that a clearing write leaves only the event-protected bits standing. They also check that irq_o agrees with the status and enable words, that start pulses are at most one-hot, that stop pulses only follow invalidate writes, that loop enables stay still without a loop write, and that non-register reads return zero. Only the bench scenarios can show the values read back over the bus. The same goes for the exact pulse timing relative to each write, and the fact that writes to unmapped offsets leave every register intact. The sweeps step through every channel, every enable and event pairing for the interrupt, and every word address.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int OFS_INVAL  = 'h140;
  localparam int OFS_STATUS = 'h144;
  localparam int OFS_ENABLE = 'h148;
  localparam int OFS_LOOP   = 'h150;
  localparam int CH_STRIDE_SHIFT = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_INVAL,
    SEL_LOOP,
    SEL_CHADDR
  } reg_sel_e;
endpackage

// File: rtl/dmareg_rst_sync.sv
module dmareg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int NUM_CH = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output reg_sel_e          sel_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              wr_o,
  output logic              rd_o
);
  localparam int CH_SPAN = NUM_CH << CH_STRIDE_SHIFT;

  logic in_chan_area;

  assign in_chan_area = (int'(req_addr) < CH_SPAN) &&
                        (req_addr[CH_STRIDE_SHIFT-1:0] == '0);

  always_comb begin
    sel_o = SEL_NONE;
    ch_o  = req_addr[CH_STRIDE_SHIFT +: CH_W];
    if (in_chan_area)                           sel_o = SEL_CHADDR;
    else if (req_addr == ADDR_W'(OFS_STATUS))   sel_o = SEL_STATUS;
    else if (req_addr == ADDR_W'(OFS_ENABLE))   sel_o = SEL_ENABLE;
    else if (req_addr == ADDR_W'(OFS_INVAL))    sel_o = SEL_INVAL;
    else if (req_addr == ADDR_W'(OFS_LOOP))     sel_o = SEL_LOOP;
  end

  assign wr_o = req_valid &&  req_write;
  assign rd_o = req_valid && !req_write;
endmodule

// File: rtl/dmareg_irq_bank.sv
module dmareg_irq_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_mask,
  input  logic              en_we,
  input  logic [NUM_CH-1:0] en_wdata,
  output logic [NUM_CH-1:0] stat_q,
  output logic [NUM_CH-1:0] en_q,
  output logic              irq_q
);
  logic [NUM_CH-1:0] stat_d;
  logic [NUM_CH-1:0] en_d;
  logic              irq_d;

  always_comb begin
    stat_d = stat_q;
    if (clr_we) stat_d = stat_d & ~clr_mask;
    stat_d = stat_d | evt_i;
    en_d   = en_we ? en_wdata : en_q;
    irq_d  = |(stat_d & en_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (en_we) en_q <= en_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/dmareg_loop_bank.sv
module dmareg_loop_bank #(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 32,
  localparam int HALF = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] loop_en_o
);
  logic [NUM_CH-1:0] lo_q, hi_q, lo_d, hi_d;

  always_comb begin
    lo_d = we ? wdata[NUM_CH-1:0]       : lo_q;
    hi_d = we ? wdata[HALF +: NUM_CH]   : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (we) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[NUM_CH-1:0]     = lo_q;
    rdata[HALF +: NUM_CH] = hi_q;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_pair
    assign loop_en_o[n] = lo_q[n] & hi_q[n];
  end
endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
  import dmareg_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [NUM_CH-1:0] evt_i,
  output logic              irq_o,
  output logic [NUM_CH-1:0] ch_start_o,
  output logic [NUM_CH-1:0] ch_stop_o,
  output logic [NUM_CH-1:0] loop_en_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              rst_sync_n;
  reg_sel_e          sel;
  logic [CH_W-1:0]   ch_idx;
  logic              bus_wr, bus_rd;
  logic [NUM_CH-1:0] stat_vec, en_vec;
  logic [DATA_W-1:0] loop_word;
  logic [DATA_W-1:0] rd_d, rd_q;
  logic [NUM_CH-1:0] start_d, start_q, stop_d, stop_q;

  dmareg_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  dmareg_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .sel_o    (sel),
    .ch_o     (ch_idx),
    .wr_o     (bus_wr),
    .rd_o     (bus_rd)
  );

  dmareg_irq_bank #(.NUM_CH(NUM_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .evt_i   (evt_i),
    .clr_we  (bus_wr && sel == SEL_STATUS),
    .clr_mask(req_wdata[NUM_CH-1:0]),
    .en_we   (bus_wr && sel == SEL_ENABLE),
    .en_wdata(req_wdata[NUM_CH-1:0]),
    .stat_q  (stat_vec),
    .en_q    (en_vec),
    .irq_q   (irq_o)
  );

  dmareg_loop_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_loop (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (bus_wr && sel == SEL_LOOP),
    .wdata    (req_wdata),
    .rdata    (loop_word),
    .loop_en_o(loop_en_o)
  );

  always_comb begin
    rd_d = '0;
    unique case (sel)
      SEL_STATUS: rd_d[NUM_CH-1:0] = stat_vec;
      SEL_ENABLE: rd_d[NUM_CH-1:0] = en_vec;
      SEL_LOOP:   rd_d = loop_word;
      default:    rd_d = '0;
    endcase
  end

  always_comb begin
    start_d = '0;
    if (bus_wr && sel == SEL_CHADDR) start_d[ch_idx] = 1'b1;
    stop_d = (bus_wr && sel == SEL_INVAL) ? req_wdata[NUM_CH-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q    <= '0;
      start_q <= '0;
      stop_q  <= '0;
    end else begin
      if (bus_rd) rd_q <= rd_d;
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end

  assign rd_data_o  = rd_q;
  assign ch_start_o = start_q;
  assign ch_stop_o  = stop_q;
endmodule

// File: rtl/dmareg_bank_chk.sv
module dmareg_bank_chk
  import dmareg_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [NUM_CH-1:0] evt_i,
  input logic              irq_o,
  input logic [NUM_CH-1:0] ch_start_o,
  input logic [NUM_CH-1:0] ch_stop_o,
  input logic [NUM_CH-1:0] loop_en_o,
  input logic [NUM_CH-1:0] stat_vec,
  input logic [NUM_CH-1:0] en_vec
);
  logic wr_stat, wr_inval, wr_loop, rd_other;

  assign wr_stat  = req_valid && req_write && req_addr == ADDR_W'(OFS_STATUS);
  assign wr_inval = req_valid && req_write && req_addr == ADDR_W'(OFS_INVAL);
  assign wr_loop  = req_valid && req_write && req_addr == ADDR_W'(OFS_LOOP);
  assign rd_other = req_valid && !req_write &&
                    req_addr != ADDR_W'(OFS_STATUS) &&
                    req_addr != ADDR_W'(OFS_ENABLE) &&
                    req_addr != ADDR_W'(OFS_LOOP);

  // R2 and R4: every event leaves its bit set, even under a clear
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((stat_vec & $past(evt_i)) == $past(evt_i)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_stat |=> ((stat_vec & $past(req_wdata[NUM_CH-1:0]) & ~$past(evt_i)) == '0));

  assert_irq_match_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o == ((stat_vec & en_vec) != '0));

  assert_stop_origin_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ch_stop_o != '0) |-> $past(wr_inval));

  assert_loop_stable_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_loop |=> $stable(loop_en_o));

  assert_start_onehot_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(ch_start_o));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_other |=> (rd_data_o == '0));
endmodule

bind dmareg_bank dmareg_bank_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rd_data_o (rd_data_o),
  .evt_i     (evt_i),
  .irq_o     (irq_o),
  .ch_start_o(ch_start_o),
  .ch_stop_o (ch_stop_o),
  .loop_en_o (loop_en_o),
  .stat_vec  (stat_vec),
  .en_vec    (en_vec)
);

// File: tb/dmareg_bank_bench.sv
module dmareg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [8:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rd_data_o;
  logic [15:0] evt_i;
  logic        irq_o;
  logic [15:0] ch_start_o;
  logic [15:0] ch_stop_o;
  logic [15:0] loop_en_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [15:0] seen_start, seen_stop;

  dmareg_bank u_dmareg_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data_o(rd_data_o),
    .evt_i(evt_i), .irq_o(irq_o), .ch_start_o(ch_start_o),
    .ch_stop_o(ch_stop_o), .loop_en_o(loop_en_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    seen_start = ch_start_o;
    seen_stop  = ch_stop_o;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data_o;
    req_valid = 1'b0;
  endtask

  task automatic pulse_evt(input logic [15:0] m);
    evt_i = m;
    @(posedge clk);
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected<100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] r;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; evt_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    bus_read(9'h144, r); check("R1 status", r, 0);
    bus_read(9'h148, r); check("R1 enable", r, 0);
    bus_read(9'h150, r); check("R1 loop", r, 0);
    check("R1 outputs", {irq_o, ch_start_o, ch_stop_o[14:0]}, 0);
    check("R1 loop_en", {16'h0, loop_en_o}, 0);

    // R2/R3 per channel set, wrong clear, right clear
    for (int n = 0; n < NCH; n++) begin
      pulse_evt(16'(1 << n));
      check("R6 masked irq", {31'h0, irq_o}, 0);
      idle();
      bus_read(9'h144, r); check("R2 status set", r, 32'(1 << n));
      bus_write(9'h144, 32'(~(1 << n)) & 32'hFFFF);
      bus_read(9'h144, r); check("R3 zero bits no effect", r, 32'(1 << n));
      bus_write(9'h144, 32'(1 << n));
      bus_read(9'h144, r); check("R3 clear", r, 0);
    end

    // R5 enable word
    bus_write(9'h148, 32'hFFFF_FFFF);
    bus_read(9'h148, r); check("R5 upper zero", r, 32'h0000_FFFF);
    bus_write(9'h148, 32'h1234_A5C3);
    bus_read(9'h148, r); check("R5 readback", r, 32'h0000_A5C3);

    // R6 sweep: enable bit n, event on n or n+1
    for (int n = 0; n < NCH; n++) begin
      for (int k = 0; k < 2; k++) begin
        int m;
        m = (n + k) % NCH;
        bus_write(9'h148, 32'(1 << n));
        check("R6 idle irq", {31'h0, irq_o}, 0);
        pulse_evt(16'(1 << m));
        check("R6 irq", {31'h0, irq_o}, {31'h0, (m == n)});
        bus_write(9'h144, 32'hFFFF);
        check("R6 irq drop", {31'h0, irq_o}, 0);
      end
    end

    // R4 event wins over same-cycle clear
    bus_write(9'h148, 32'hFFFF);
    for (int n = 0; n < NCH; n += 5) begin
      pulse_evt(16'(1 << n));
      evt_i = 16'(1 << n);
      bus_write(9'h144, 32'(1 << n));
      evt_i = '0;
      bus_read(9'h144, r); check("R4 event wins", r, 32'(1 << n));
      check("R4 irq held", {31'h0, irq_o}, 1);
      bus_write(9'h144, 32'(1 << n));
    end
    bus_write(9'h148, 0);

    // R7 stop pulses
    for (int n = 0; n < NCH; n++) begin
      bus_write(9'h140, 32'(1 << n));
      check("R7 stop pulse", {16'h0, seen_stop}, 32'(1 << n));
      idle();
      check("R7 stop one cycle", {16'h0, ch_stop_o}, 0);
    end
    bus_read(9'h140, r); check("R7 reads zero", r, 0);

    // R8 loop pairs
    for (int n = 0; n < NCH; n++) begin
      bus_write(9'h150, 32'(1 << n));
      check("R8 low only", {16'h0, loop_en_o}, 0);
      bus_write(9'h150, 32'(1 << (n + 16)));
      check("R8 high only", {16'h0, loop_en_o}, 0);
      bus_write(9'h150, 32'(1 << n) | 32'(1 << (n + 16)));
      check("R8 both", {16'h0, loop_en_o}, 32'(1 << n));
      bus_read(9'h150, r); check("R8 readback", r, 32'(1 << n) | 32'(1 << (n + 16)));
    end
    bus_write(9'h150, 32'h00FF_0F0F);
    check("R8 mixed", {16'h0, loop_en_o}, 32'h0000_0F0F & 32'h0000_00FF);

    // R9 start pulses, R10 other channel words
    for (int n = 0; n < NCH; n++) begin
      bus_write(9'(n * 16), 32'hDEAD_0000 + 32'(n));
      check("R9 start pulse", {16'h0, seen_start}, 32'(1 << n));
      idle();
      check("R9 start one cycle", {16'h0, ch_start_o}, 0);
      bus_write(9'(n * 16 + 4), 32'hFFFF_FFFF);
      check("R10 no start", {16'h0, seen_start}, 0);
    end

    // R10 sweep: load registers, write/read every unmapped word
    bus_write(9'h148, 32'h0000_3C3C);
    pulse_evt(16'h8001);
    for (int a = 0; a < 512; a += 4) begin
      if (a == 'h140 || a == 'h144 || a == 'h148 || a == 'h150) continue;
      if (a < 256 && (a % 16) == 0) continue;
      bus_write(9'(a), 32'hFFFF_FFFF);
      if (seen_start != 0 || seen_stop != 0)
        check("R10 write no pulse", {seen_start, seen_stop}, 0);
      bus_read(9'(a), r);
      if (r != 0) check("R10 unmapped read", r, 0);
    end
    for (int a = 0; a < 256; a += 16) begin
      bus_read(9'(a), r);
      if (r != 0) check("R10 chaddr read", r, 0);
    end
    total++;
    bus_read(9'h148, r); check("R10 enable kept", r, 32'h0000_3C3C);
    bus_read(9'h144, r); check("R10 status kept", r, 32'h0000_8001);
    bus_read(9'h150, r); check("R10 loop kept", r, 32'h00FF_0F0F);

    // R11 read data holds
    bus_read(9'h148, r);
    idle(); idle();
    check("R11 hold", rd_data_o, 32'h0000_3C3C);
    bus_write(9'h148, 0);
    check("R11 hold over write", rd_data_o, 32'h0000_3C3C);

    finish_run();
  end
endmodule